// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block merges three internal reset causes (a power-on pulse, a low-supply level and a watchdog time-out) into one active-low system reset. It also runs the stop-mode handshake. A stop strobe halts the oscillator enable. A low level on any wake line brings the oscillator back. After a fixed settling interval, instruction execution may resume.

A binary counter of `WDT_BITS` stages advances once per machine-cycle tick. The tick is the system clock divided by `DIV_SLOW` (default 48) or by `DIV_FAST` (default 12), chosen by `fast_sel`. The counter reaches its time-out after 2^(WDT_BITS-1) ticks. That same time-out does two jobs: it raises the reset while the system is running, and it releases the reset while the reset is held. Settling after a wake-up is counted on the free-running `clk` input with a separate counter, because the modelled oscillator enable is low during stop. Below, T = 2^(WDT_BITS-1) × D, where D is the selected divisor.

Top module: `wdt_reset_seq`

## Requirements
- R1: While `por_pulse` is high, `sys_rst_n` is 0, `osc_en` is 1 and `stop_active` is 0.
- R2: `sys_rst_n` rises exactly T clock edges after the last edge with `por_pulse` high. D is `DIV_SLOW` when `fast_sel`=0 and `DIV_FAST` when `fast_sel`=1.
- R3: With no clear, a running system sees `sys_rst_n` fall T edges after it rose, then rise again T edges later.
- R4: A one-cycle `wdt_clr` clears the counter and the prescaler, so the next time-out comes exactly T edges after the clearing edge.
- R5: While `lvd_flag` is high, `sys_rst_n` is 0 from the next edge on. `sys_rst_n` rises exactly T edges after the last edge with `lvd_flag` high.
- R6: A `stop_req` strobe with reset released and all wake lines high drives `osc_en` to 0 and `stop_active` to 1 on the next edge.
- R7: During stop the watchdog is held cleared, so `sys_rst_n` stays 1 however long stop lasts.
- R8: A low level on any single bit of `wake_n` raises `osc_en` on the third edge after it is applied (two synchroniser stages, then the state change). `stop_active` falls `SETTLE_CLKS` edges after that.
- R9: After a wake-up, the watchdog restarts from zero, and the time-out comes T edges after `stop_active` falls.
- R10: A `stop_req` given while any synchronised wake line is already low has no effect: `stop_active` stays 0 and `osc_en` stays 1.
- R11: A `stop_req` given while `sys_rst_n` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| por_pulse | input | 1 | Power-on pulse, active high; also the block's own initialiser |
| lvd_flag | input | 1 | Low-supply detect level, active high |
| wdt_clr | input | 1 | Watchdog clear strobe |
| stop_req | input | 1 | Stop instruction strobe |
| fast_sel | input | 1 | Tick divisor select: 0 = DIV_SLOW, 1 = DIV_FAST |
| wake_n | input | WAKE_N | Active-low key and return wake inputs |
| sys_rst_n | output | 1 | System reset, active low |
| osc_en | output | 1 | Oscillator run enable |
| stop_active | output | 1 | High from stop entry until settling ends |

## Verification
The hardest case to reach from the ports is a time-out that comes right after a wake-up. It needs three things in a row: a released reset, a stop that is accepted, and a wake that passes through the synchroniser. Only after all three does the bench learn that the counter really restarted from zero. The bench gets there by releasing the reset, waiting long enough for the wake lines to settle high, and pulsing stop. It then drops each wake line in turn and counts edges to the settling end and on to the next time-out. The bench builds the design with a small counter, small divisors and a short settle count, so that it can sweep every wake line, both divisors and several clear points.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wrs_tick_gen.sv
module wrs_tick_gen #(
    parameter int DIV_SLOW = 48,
    parameter int DIV_FAST = 12
) (
    input  logic clk,
    input  logic por,
    input  logic clr,
    input  logic hold,
    input  logic fast_sel,
    output logic tick
);
    localparam int DIV_W = $clog2(DIV_SLOW);
    localparam logic [DIV_W-1:0] LAST_S = DIV_W'(DIV_SLOW - 1);
    localparam logic [DIV_W-1:0] LAST_F = DIV_W'(DIV_FAST - 1);

    logic [DIV_W-1:0] div_d, div_q;
    logic             at_last;

    always_comb begin
        at_last = fast_sel ? (div_q >= LAST_F) : (div_q >= LAST_S);
        tick    = at_last && !clr && !hold && !por;
        if (por || clr || hold || at_last) div_d = '0;
        else                               div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) div_q <= div_d;

    // Divisors are at least two, so ticks never come back to back.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (por)
        tick |=> !tick);
endmodule

// File: rtl/wrs_wdt_count.sv
module wrs_wdt_count #(
    parameter int WDT_BITS = 14
) (
    input  logic clk,
    input  logic por,
    input  logic clr,
    input  logic tick,
    output logic ovf
);
    localparam logic [WDT_BITS-1:0] OVF_LAST = WDT_BITS'((2 ** (WDT_BITS - 1)) - 1);

    logic [WDT_BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        ovf = tick && !clr && !por && (cnt_q == OVF_LAST);
        if (por || clr || ovf) cnt_d = '0;
        else if (tick)         cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (por)
        clr |=> (cnt_q == '0));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (por)
        cnt_q <= OVF_LAST);
endmodule

// File: rtl/wrs_wake_sync.sv
module wrs_wake_sync #(
    parameter int WAKE_N = 8
) (
    input  logic              clk,
    input  logic [WAKE_N-1:0] wake_n,
    output logic              any_low
);
    logic [WAKE_N-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d    = wake_n;
        s2_d    = s1_q;
        any_low = ~&s2_q;
    end

    always_ff @(posedge clk) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
    end
endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq #(
    parameter int WDT_BITS    = 14,
    parameter int DIV_SLOW    = 48,
    parameter int DIV_FAST    = 12,
    parameter int SETTLE_CLKS = 8192,
    parameter int WAKE_N      = 8
) (
    input  logic              clk,
    input  logic              por_pulse,
    input  logic              lvd_flag,
    input  logic              wdt_clr,
    input  logic              stop_req,
    input  logic              fast_sel,
    input  logic [WAKE_N-1:0] wake_n,
    output logic              sys_rst_n,
    output logic              osc_en,
    output logic              stop_active
);
    import wrs_pkg::*;

    localparam int ST_W = $clog2(SETTLE_CLKS);
    localparam logic [ST_W-1:0] SETTLE_LAST = ST_W'(SETTLE_CLKS - 1);

    typedef struct packed {
        seq_state_e      st;
        logic            rst;
        logic [ST_W-1:0] stc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic wake_low, tick, wdt_ovf, hold_wdt, clr_wdt;

    wrs_wake_sync #(.WAKE_N(WAKE_N)) u_sync (
        .clk(clk), .wake_n(wake_n), .any_low(wake_low)
    );

    wrs_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
        .clk(clk), .por(por_pulse), .clr(clr_wdt), .hold(hold_wdt),
        .fast_sel(fast_sel), .tick(tick)
    );

    wrs_wdt_count #(.WDT_BITS(WDT_BITS)) u_wdt (
        .clk(clk), .por(por_pulse), .clr(clr_wdt || hold_wdt),
        .tick(tick), .ovf(wdt_ovf)
    );

    always_comb begin
        hold_wdt = (seq_q.st != ST_RUN);
        clr_wdt  = lvd_flag || wdt_clr;
        seq_d    = seq_q;
        if (por_pulse || lvd_flag) begin
            seq_d.st  = ST_RUN;
            seq_d.rst = 1'b1;
            seq_d.stc = '0;
        end else begin
            if (wdt_ovf) seq_d.rst = !seq_q.rst;
            unique case (seq_q.st)
                ST_RUN: begin
                    if (stop_req && !seq_q.rst && !wdt_ovf && !wake_low)
                        seq_d.st = ST_STOP;
                end
                ST_STOP: begin
                    if (wake_low) begin
                        seq_d.st  = ST_SETTLE;
                        seq_d.stc = '0;
                    end
                end
                ST_SETTLE: begin
                    if (seq_q.stc == SETTLE_LAST) begin
                        seq_d.st  = ST_RUN;
                        seq_d.stc = '0;
                    end else begin
                        seq_d.stc = seq_q.stc + 1'b1;
                    end
                end
                default: seq_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) seq_q <= seq_d;

    assign sys_rst_n   = !seq_q.rst;
    assign osc_en      = (seq_q.st != ST_STOP);
    assign stop_active = (seq_q.st != ST_RUN);

    assert_release_on_ovf_R2: assert property (@(posedge clk) disable iff (por_pulse)
        $rose(sys_rst_n) |-> $past(wdt_ovf));
    assert_lvd_holds_R5: assert property (@(posedge clk) disable iff (por_pulse)
        lvd_flag |=> !sys_rst_n);
    assert_stop_from_strobe_R6: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(osc_en) |-> $past(stop_req));
    assert_no_bite_in_stop_R7: assert property (@(posedge clk) disable iff (por_pulse)
        (stop_active && sys_rst_n && !lvd_flag) |=> sys_rst_n);
    assert_stop_noop_R10: assert property (@(posedge clk) disable iff (por_pulse)
        (stop_req && wake_low && !stop_active) |=> !stop_active);
    assert_stop_in_reset_R11: assert property (@(posedge clk) disable iff (por_pulse)
        (!sys_rst_n && !stop_active) |=> !stop_active);
endmodule

// File: tb/sim_wdt_reset_seq.sv
module sim_wdt_reset_seq;
    localparam int WB = 6;
    localparam int DS = 4;
    localparam int DF = 2;
    localparam int SC = 16;
    localparam int WN = 8;
    localparam int TICKS = 2 ** (WB - 1);

    logic clk = 1'b0;
    logic por_pulse = 1'b1, lvd_flag = 1'b0, wdt_clr = 1'b0, stop_req = 1'b0, fast_sel = 1'b0;
    logic [WN-1:0] wake_n = '1;
    logic sys_rst_n, osc_en, stop_active;
    int tests = 0, fails = 0;
    int win;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_reset_seq #(.WDT_BITS(WB), .DIV_SLOW(DS), .DIV_FAST(DF),
                    .SETTLE_CLKS(SC), .WAKE_N(WN)) u0 (
        .clk(clk), .por_pulse(por_pulse), .lvd_flag(lvd_flag), .wdt_clr(wdt_clr),
        .stop_req(stop_req), .fast_sel(fast_sel), .wake_n(wake_n),
        .sys_rst_n(sys_rst_n), .osc_en(osc_en), .stop_active(stop_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_stop();
        stop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    initial begin
        edges(3);
        chk("R1 rst_n", sys_rst_n, 0);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 stop_active", stop_active, 0);

        for (int f = 0; f < 2; f++) begin
            fast_sel = f[0];
            win = TICKS * (f == 1 ? DF : DS);
            por_pulse = 1'b1;
            edges(2);
            chk("R1 rst_n in por", sys_rst_n, 0);
            por_pulse = 1'b0;
            edges(win - 1); chk("R2 before release", sys_rst_n, 0);
            edges(1);       chk("R2 release", sys_rst_n, 1);
            edges(win - 1); chk("R3 before bite", sys_rst_n, 1);
            edges(1);       chk("R3 bite", sys_rst_n, 0);
            edges(win - 1); chk("R3 held", sys_rst_n, 0);
            edges(1);       chk("R3 re-release", sys_rst_n, 1);
            for (int k = 1; k < win; k += win / 5 + 1) begin
                edges(k - 1);
                wdt_clr = 1'b1;
                @(posedge clk); @(negedge clk);
                wdt_clr = 1'b0;
                edges(win - 1); chk("R4 full window after clear", sys_rst_n, 1);
                edges(1);       chk("R4 bite after clear", sys_rst_n, 0);
                edges(win);     chk("R4 release", sys_rst_n, 1);
            end
            edges(5);
            lvd_flag = 1'b1;
            edges(1); chk("R5 lvd asserts", sys_rst_n, 0);
            edges(win + 7); chk("R5 lvd holds", sys_rst_n, 0);
            lvd_flag = 1'b0;
            edges(win - 1); chk("R5 before release", sys_rst_n, 0);
            edges(1);       chk("R5 release", sys_rst_n, 1);
        end

        fast_sel = 1'b0;
        win = TICKS * DS;
        for (int i = 0; i < WN; i++) begin
            edges(3);
            strobe_stop();
            chk("R6 osc_en", osc_en, 0);
            chk("R6 stop_active", stop_active, 1);
            edges(3 * win);
            chk("R7 no bite", sys_rst_n, 1);
            chk("R7 still stopped", osc_en, 0);
            wake_n[i] = 1'b0;
            edges(2); chk("R8 osc_en before sync", osc_en, 0);
            edges(1); chk("R8 osc_en after sync", osc_en, 1);
            edges(SC - 1); chk("R8 settling", stop_active, 1);
            edges(1);      chk("R8 settle end", stop_active, 0);
            wake_n[i] = 1'b1;
            edges(win - 1); chk("R9 before bite", sys_rst_n, 1);
            edges(1);       chk("R9 bite after resume", sys_rst_n, 0);
            edges(win);     chk("R9 release", sys_rst_n, 1);
        end

        for (int j = 0; j < WN; j++) begin
            wake_n[j] = 1'b0;
            edges(3);
            strobe_stop();
            edges(2);
            chk("R10 stop_active", stop_active, 0);
            chk("R10 osc_en", osc_en, 1);
            wake_n[j] = 1'b1;
        end

        edges(3);
        lvd_flag = 1'b1;
        edges(2);
        lvd_flag = 1'b0;
        edges(2);
        chk("R11 in reset", sys_rst_n, 0);
        strobe_stop();
        chk("R11 stop ignored", stop_active, 0);
        chk("R11 osc_en", osc_en, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule